// File: doc/BRIEF.md
# Resistive Touchscreen Scan Sequencer

This block runs the automatic measurement loop of a 4-wire resistive touch panel from a slow timing clock. Once scanning is enabled it walks a fixed chain of phases for every coordinate pair. The chain is a settle delay, an X conversion, a second settle delay, a Y conversion, a discharge delay, a touch-detect delay and an update delay. Each delay phase has its own programmable clock count. Conversions use a request/done handshake with an external converter that returns a 10-bit value.

At the end of the touch-detect phase the block packs the X result, the Y result and the pen level into one word. It pushes that word into a small sample FIFO. A level interrupt tells the host when enough samples are waiting. The host reaches control, timing, window, status and FIFO-pop registers through a simple word-addressed read/write port. Read data is combinational for the address presented, and a read of the data register pops the FIFO on the clock edge.

Register word addresses are: 0 control, 1 status, 2 sample data (pop), 3 first settle delay, 4 second settle delay, 5 discharge delay, 6 touch-detect delay, 7 update delay, 8 X window low, 9 X window high, 10 Y window low and 11 Y window high.

Top module: `tscan_top`

## Requirements
- R1: After reset the control register reads 0 and status reads 0x080. The five delay registers read 2, 2, 4, 16 and 88. The window registers read 0, 0x3FF, 0 and 0x3FF. The outputs irq, adc_req and adc_pwr are 0.
- R2: With control bit 0 set, every pair issues an X conversion request (adc_chan = 0) and then a Y conversion request (adc_chan = 1). A delay phase programmed to N lasts max(N,1) clocks, and a conversion lasts until adc_done. The time between successive X requests is therefore the sum of the five delays plus both conversion times.
- R3: Each FIFO word holds X in bits 25:16, Y in bits 9:0 and the pen level in bit 31. All other bits are 0. Bit 31 is 0 when pen_down is high in the last touch-detect clock, and 1 when it is low.
- R4: Control bits 9:7 (X) and 6:4 (Y) each hold a value f = 10 minus the resolution. The stored result is the converter value with its low f bits cleared, so f = 0 keeps all 10 bits.
- R5: Each read of the data register returns and removes the oldest entry, in push order. A read while the FIFO is empty returns the most recently removed word and leaves the occupancy at 0.
- R6: Status bit 7 is 1 when the FIFO is empty, bit 8 is the overrun flag, and bits 3:0 give the occupancy (depth 8).
- R7: A sample that completes while the FIFO holds 8 entries is dropped and sets the overrun flag. The flag stays set while entries remain and clears when the FIFO becomes empty.
- R8: irq is high exactly while the occupancy is at or above the trigger level. The trigger level is 4 when control bit 11 is set and 1 otherwise.
- R9: Clearing control bit 0 lets the current phase finish and then halts the sequence. An open conversion request is held until adc_done, and afterwards no further requests or samples appear.
- R10: Control bit 2 drives adc_pwr directly and reads back from the control register.
- R11: The control register reads back its writable bits 0, 2, 4 to 9 and 11 (mask 0xBF5). The delay registers read back 8 bits, and the window registers read back 10 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on data address) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| adc_req | output | 1 | Conversion request, held until done |
| adc_chan | output | 1 | Axis being converted: 0 = X, 1 = Y |
| adc_done | input | 1 | Conversion complete, value valid |
| adc_value | input | 10 | Converter result |
| adc_pwr | output | 1 | Converter power-up control |
| pen_down | input | 1 | Touch sense, high while the panel is pressed |
| irq | output | 1 | Level interrupt on FIFO occupancy |

## Verification
The scan loop runs under randomly chosen delay counts, conversion latencies, resolution fields, pen states and trigger levels. The converter returns a fresh random value on every conversion. Because of this, a word stored out of order, with the axes swapped or with the wrong mask no longer matches its recorded pair. Three directed runs cover the rest. All-zero delays separate the one-clock minimum from a zero-length or off-by-one phase. The reset timing exposes errors in the default counts. A run that fills the FIFO past depth tells a dropped sample apart from an overwritten one, and a sticky overrun flag apart from one that clears too early or too late.

// File: rtl/tscan_pkg.sv
package tscan_pkg;

    localparam int SMP_W  = 10;
    localparam int DLY_W  = 8;
    localparam int ADDR_W = 4;
    localparam int RES_W  = 3;
    localparam int N_DLY  = 5;
    localparam int N_WIN  = 4;

    // register word addresses
    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_STAT  = 4'd1;
    localparam logic [ADDR_W-1:0] A_DATA  = 4'd2;
    localparam logic [ADDR_W-1:0] A_DLY0  = 4'd3;
    localparam logic [ADDR_W-1:0] A_DLY4  = 4'd7;
    localparam logic [ADDR_W-1:0] A_WIN0  = 4'd8;
    localparam logic [ADDR_W-1:0] A_WIN3  = 4'd11;

    // control and status bit positions
    localparam int CB_EN    = 0;
    localparam int CB_PWR   = 2;
    localparam int CB_YRES  = 4;
    localparam int CB_XRES  = 7;
    localparam int CB_TRIG  = 11;
    localparam int SB_EMPTY = 7;
    localparam int SB_OVR   = 8;

    // sample word layout
    localparam int W_PEN  = 31;
    localparam int W_XLO  = 16;
    localparam int W_YLO  = 0;

    typedef struct packed {
        logic             en;
        logic             pwr;
        logic             trig_hi;
        logic [RES_W-1:0] xdrop;
        logic [RES_W-1:0] ydrop;
    } ctrl_t;

    typedef struct packed {
        logic [DLY_W-1:0] settle_x;
        logic [DLY_W-1:0] settle_y;
        logic [DLY_W-1:0] drain;
        logic [DLY_W-1:0] touch;
        logic [DLY_W-1:0] update;
    } timing_t;

    typedef struct packed {
        logic             pen_up;
        logic [SMP_W-1:0] x;
        logic [SMP_W-1:0] y;
    } sample_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETTLE_X,
        PH_CONV_X,
        PH_SETTLE_Y,
        PH_CONV_Y,
        PH_DRAIN,
        PH_TOUCH,
        PH_UPDATE
    } phase_e;

    function automatic phase_e next_phase(phase_e p);
        case (p)
            PH_IDLE:     return PH_SETTLE_X;
            PH_SETTLE_X: return PH_CONV_X;
            PH_CONV_X:   return PH_SETTLE_Y;
            PH_SETTLE_Y: return PH_CONV_Y;
            PH_CONV_Y:   return PH_DRAIN;
            PH_DRAIN:    return PH_TOUCH;
            PH_TOUCH:    return PH_UPDATE;
            default:     return PH_SETTLE_X;
        endcase
    endfunction

    function automatic logic [DLY_W-1:0] dly_default(int i);
        case (i)
            0, 1:    return DLY_W'(2);
            2:       return DLY_W'(4);
            3:       return DLY_W'(16);
            default: return DLY_W'(88);
        endcase
    endfunction

    function automatic logic [SMP_W-1:0] win_default(int i);
        return (i % 2 == 1) ? {SMP_W{1'b1}} : '0;
    endfunction

    function automatic logic [SMP_W-1:0] trim(logic [SMP_W-1:0] v, logic [RES_W-1:0] drop);
        return v & ({SMP_W{1'b1}} << drop);
    endfunction

    function automatic logic [31:0] pack_word(sample_t s);
        logic [31:0] w;
        w = '0;
        w[W_PEN] = s.pen_up;
        w[W_XLO +: SMP_W] = s.x;
        w[W_YLO +: SMP_W] = s.y;
        return w;
    endfunction

    function automatic logic [31:0] ctrl_word(ctrl_t c);
        logic [31:0] w;
        w = '0;
        w[CB_EN]  = c.en;
        w[CB_PWR] = c.pwr;
        w[CB_TRIG] = c.trig_hi;
        w[CB_XRES +: RES_W] = c.xdrop;
        w[CB_YRES +: RES_W] = c.ydrop;
        return w;
    endfunction

endpackage

// File: rtl/tscan_fifo.sv
module tscan_fifo
    import tscan_pkg::*;
#(
    parameter int  DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  sample_t          wdata,
    input  logic             pop,
    output sample_t          rdata,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full,
    output logic             ovr
);

    sample_t          mem [DEPTH];
    sample_t          last_q;
    logic [PTR_W-1:0] wptr_q, rptr_q, wptr_inc, rptr_inc;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ovr_q;
    logic             do_push, do_pop;

    generate
        if ((1 << PTR_W) == DEPTH) begin : g_pow2
            assign wptr_inc = wptr_q + 1'b1;
            assign rptr_inc = rptr_q + 1'b1;
        end else begin : g_wrap
            assign wptr_inc = (wptr_q == PTR_W'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
            assign rptr_inc = (rptr_q == PTR_W'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
        end
    endgenerate

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);

    always_comb begin
        cnt_d = cnt_q;
        if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
        else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr_q] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
            ovr_q  <= 1'b0;
            last_q <= '0;
        end else begin
            if (do_push) wptr_q <= wptr_inc;
            if (do_pop) begin
                rptr_q <= rptr_inc;
                last_q <= mem[rptr_q];
            end
            cnt_q <= cnt_d;
            if (cnt_d == '0)           ovr_q <= 1'b0;
            else if (push && !do_push) ovr_q <= 1'b1;
        end
    end

    assign rdata = empty ? last_q : mem[rptr_q];
    assign count = cnt_q;
    assign ovr   = ovr_q;

    // R7: occupancy never exceeds the depth
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH));

    // R7: a push into a full FIFO without a pop keeps it full and flags overrun
    p_drop_full_r7: assert property (@(posedge clk) disable iff (rst)
        full && push && !pop |=> full && ovr_q);

    // R7: the overrun flag is never seen with an empty FIFO
    p_ovr_clear_r7: assert property (@(posedge clk) disable iff (rst)
        empty |-> !ovr_q);

    // R5: popping an empty FIFO moves nothing and keeps the returned word
    p_empty_pop_r5: assert property (@(posedge clk) disable iff (rst)
        pop && !push && empty |=> empty && $stable(rdata));

endmodule

// File: rtl/tscan_seq.sv
module tscan_seq
    import tscan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  timing_t          tim,
    input  logic             pen_down,
    output logic             adc_req,
    output logic             adc_chan,
    input  logic             adc_done,
    input  logic [SMP_W-1:0] adc_value,
    output logic             push,
    output sample_t          smp
);

    phase_e           ph_q, ph_d;
    logic [DLY_W-1:0] cnt_q, len;
    logic [SMP_W-1:0] x_q, y_q;
    logic             last_tick, step;

    always_comb begin
        case (ph_q)
            PH_SETTLE_X: len = tim.settle_x;
            PH_SETTLE_Y: len = tim.settle_y;
            PH_DRAIN:    len = tim.drain;
            PH_TOUCH:    len = tim.touch;
            PH_UPDATE:   len = tim.update;
            default:     len = '0;
        endcase
    end

    // a delay of N lasts max(N,1) clocks
    assign last_tick = (len <= DLY_W'(1)) || (cnt_q == len - 1'b1);

    always_comb begin
        case (ph_q)
            PH_IDLE:              step = ctrl.en;
            PH_CONV_X, PH_CONV_Y: step = adc_done;
            default:              step = last_tick;
        endcase
    end

    always_comb begin
        ph_d = ph_q;
        if (step) begin
            if (ph_q != PH_IDLE && !ctrl.en) ph_d = PH_IDLE;
            else                             ph_d = next_phase(ph_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
            x_q   <= '0;
            y_q   <= '0;
        end else begin
            ph_q <= ph_d;
            if (step || ph_q == PH_IDLE) cnt_q <= '0;
            else                         cnt_q <= cnt_q + 1'b1;
            if (ph_q == PH_CONV_X && adc_done) x_q <= trim(adc_value, ctrl.xdrop);
            if (ph_q == PH_CONV_Y && adc_done) y_q <= trim(adc_value, ctrl.ydrop);
        end
    end

    assign adc_req    = (ph_q == PH_CONV_X) || (ph_q == PH_CONV_Y);
    assign adc_chan   = (ph_q == PH_CONV_Y);
    assign push       = (ph_q == PH_TOUCH) && step;
    assign smp.pen_up = !pen_down;
    assign smp.x      = x_q;
    assign smp.y      = y_q;

    // R9: an open request is held, on the same axis, until the converter answers
    p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
        adc_req && !adc_done |=> adc_req && $stable(adc_chan));

    // R9: a halted sequencer with scanning off issues no request
    p_halt_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !ctrl.en && ph_q == PH_IDLE |=> !adc_req);

endmodule

// File: rtl/tscan_regs.sv
module tscan_regs
    import tscan_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output ctrl_t             ctrl,
    output timing_t           tim,
    input  sample_t           head,
    input  logic [CNT_W-1:0]  count,
    input  logic              empty,
    input  logic              ovr,
    output logic              pop
);

    ctrl_t            ctrl_q;
    logic [DLY_W-1:0] dly_q [N_DLY];
    logic [SMP_W-1:0] win_q [N_WIN];
    logic [ADDR_W-1:0] dly_idx;
    logic             unused_wbits;

    assign unused_wbits = ^{reg_wdata[31:12], reg_wdata[10], reg_wdata[3], reg_wdata[1]};
    assign dly_idx      = reg_addr - A_DLY0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            for (int i = 0; i < N_DLY; i++) dly_q[i] <= dly_default(i);
            for (int i = 0; i < N_WIN; i++) win_q[i] <= win_default(i);
        end else if (reg_wr) begin
            if (reg_addr == A_CTRL) begin
                ctrl_q.en      <= reg_wdata[CB_EN];
                ctrl_q.pwr     <= reg_wdata[CB_PWR];
                ctrl_q.trig_hi <= reg_wdata[CB_TRIG];
                ctrl_q.xdrop   <= reg_wdata[CB_XRES +: RES_W];
                ctrl_q.ydrop   <= reg_wdata[CB_YRES +: RES_W];
            end
            for (int i = 0; i < N_DLY; i++)
                if (reg_addr == ADDR_W'(32'(A_DLY0) + i)) dly_q[i] <= reg_wdata[DLY_W-1:0];
            for (int i = 0; i < N_WIN; i++)
                if (reg_addr == ADDR_W'(32'(A_WIN0) + i)) win_q[i] <= reg_wdata[SMP_W-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTRL) begin
            reg_rdata = ctrl_word(ctrl_q);
        end else if (reg_addr == A_STAT) begin
            reg_rdata[SB_EMPTY]    = empty;
            reg_rdata[SB_OVR]      = ovr;
            reg_rdata[CNT_W-1:0]   = count;
        end else if (reg_addr == A_DATA) begin
            reg_rdata = pack_word(head);
        end else if (reg_addr >= A_DLY0 && reg_addr <= A_DLY4) begin
            reg_rdata[DLY_W-1:0] = dly_q[dly_idx[2:0]];
        end else if (reg_addr >= A_WIN0 && reg_addr <= A_WIN3) begin
            reg_rdata[SMP_W-1:0] = win_q[reg_addr[1:0]];
        end
    end

    assign pop  = reg_rd && (reg_addr == A_DATA);
    assign ctrl = ctrl_q;
    assign tim  = '{settle_x: dly_q[0], settle_y: dly_q[1], drain: dly_q[2],
                    touch: dly_q[3], update: dly_q[4]};

    // R11: a control write lands in the register on the next clock
    p_ctrl_write_r11: assert property (@(posedge clk) disable iff (rst)
        reg_wr && reg_addr == A_CTRL |=> ctrl_q.en == $past(reg_wdata[CB_EN]));

endmodule

// File: rtl/tscan_top.sv
module tscan_top
    import tscan_pkg::*;
#(
    parameter int  FIFO_DEPTH = 8,
    parameter int  TRIG_LO    = 1,
    parameter int  TRIG_HI    = 4,
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              adc_req,
    output logic              adc_chan,
    input  logic              adc_done,
    input  logic [SMP_W-1:0]  adc_value,
    output logic              adc_pwr,
    input  logic              pen_down,
    output logic              irq
);

    ctrl_t            ctrl;
    timing_t          tim;
    sample_t          smp, head;
    logic             push, pop, empty, full, ovr;
    logic [CNT_W-1:0] count;

    tscan_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ctrl(ctrl), .tim(tim), .head(head), .count(count),
        .empty(empty), .ovr(ovr), .pop(pop)
    );

    tscan_seq u_seq (
        .clk(clk), .rst(rst), .ctrl(ctrl), .tim(tim), .pen_down(pen_down),
        .adc_req(adc_req), .adc_chan(adc_chan), .adc_done(adc_done),
        .adc_value(adc_value), .push(push), .smp(smp)
    );

    tscan_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .wdata(smp), .pop(pop),
        .rdata(head), .count(count), .empty(empty), .full(full), .ovr(ovr)
    );

    assign irq     = count >= (ctrl.trig_hi ? CNT_W'(TRIG_HI) : CNT_W'(TRIG_LO));
    assign adc_pwr = ctrl.pwr;

    // R8: no interrupt with nothing stored
    p_irq_empty_r8: assert property (@(posedge clk) disable iff (rst)
        empty |-> !irq);

    // R8: a full FIFO always requests service
    p_irq_full_r8: assert property (@(posedge clk) disable iff (rst)
        full |-> irq);

endmodule

// File: tb/tscan_top_test.sv
module tscan_top_test;

    localparam logic [3:0] R_CTRL = 4'd0;
    localparam logic [3:0] R_STAT = 4'd1;
    localparam logic [3:0] R_DATA = 4'd2;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr, reg_rd;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        adc_req, adc_chan, adc_done, adc_pwr, pen_down, irq;
    logic [9:0]  adc_value;

    int n_chk = 0;
    int n_fail = 0;

    // converter model and monitor state
    int         lat = 1;
    int         acnt = 0;
    logic [9:0] xs [64];
    logic [9:0] ys [64];
    int         pidx = 0;
    int         cyc = 0;
    int         nrise = 0;
    int         t_prev = 0;
    int         t_last = 0;
    int         chan_err = 0;
    logic       exp_chan = 1'b0;
    logic       prev_req = 1'b0;

    always #4 clk = ~clk;

    tscan_top uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .adc_req(adc_req), .adc_chan(adc_chan), .adc_done(adc_done),
        .adc_value(adc_value), .adc_pwr(adc_pwr), .pen_down(pen_down), .irq(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic int mx1(int n);
        return (n < 1) ? 1 : n;
    endfunction

    function automatic logic [31:0] exp_word(int i, bit pen, int fx, int fy);
        logic [31:0] w;
        w = '0;
        w[31]    = !pen;
        w[25:16] = xs[i] & (10'h3FF << fx);
        w[9:0]   = ys[i] & (10'h3FF << fy);
        return w;
    endfunction

    // converter: answers after lat clocks with a fresh random value
    initial begin
        adc_done = 1'b0;
        adc_value = '0;
        forever begin
            @(negedge clk);
            if (adc_req && !adc_done) begin
                acnt++;
                if (acnt == lat) begin
                    adc_value = 10'($urandom);
                    adc_done = 1'b1;
                    if (!adc_chan) xs[pidx] = adc_value;
                    else begin
                        ys[pidx] = adc_value;
                        if (pidx < 63) pidx++;
                    end
                end
            end else begin
                acnt = 0;
                adc_done = 1'b0;
            end
        end
    end

    // request monitor: axis order and X-to-X period
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (adc_req && !prev_req) begin
                if (adc_chan !== exp_chan) chan_err++;
                exp_chan = ~exp_chan;
                if (!adc_chan) begin
                    t_prev = t_last;
                    t_last = cyc;
                    nrise++;
                end
            end
            prev_req = adc_req;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (R2 scan progress): actual timeout expected completion");
        summary();
        $finish;
    end

    task automatic prep(int a, int b, int d, int t, int u, int lt, bit pen);
        wr(4'd3, 32'(a)); wr(4'd4, 32'(b)); wr(4'd5, 32'(d));
        wr(4'd6, 32'(t)); wr(4'd7, 32'(u));
        lat = lt; pidx = 0; exp_chan = 1'b0; nrise = 0; chan_err = 0;
        pen_down = pen;
    endtask

    task automatic run_seg(string nm, int a, int b, int d, int t, int u,
                           int lt, int fx, int fy, bit pen, bit trig, int want);
        logic [31:0] s, w;
        logic [31:0] cbits;
        int c1;
        prep(a, b, d, t, u, lt, pen);
        cbits = (32'(fy) << 4) | (32'(fx) << 7) | (32'(trig) << 11);
        wr(R_CTRL, cbits | 32'h1);
        for (int k = 0; k < 4000; k++) begin
            rd(R_STAT, s);
            if (int'(s[3:0]) >= want) break;
        end
        wr(R_CTRL, cbits);
        repeat (60) @(negedge clk);
        rd(R_STAT, s);
        c1 = int'(s[3:0]);
        repeat (100) @(negedge clk);
        rd(R_STAT, w);
        check($sformatf("R9 %s no sample after stop", nm), w, s);
        check($sformatf("R9 %s no request after stop", nm), 32'(adc_req), 32'h0);
        check($sformatf("R2 %s X/Y order", nm), 32'(chan_err), 32'h0);
        check($sformatf("R2 %s enough pairs", nm), 32'(nrise >= 2), 32'h1);
        check($sformatf("R2 %s pair period", nm), 32'(t_last - t_prev),
              32'(mx1(a) + mx1(b) + mx1(d) + mx1(t) + mx1(u) + 2 * lt));
        check($sformatf("R8 %s irq level", nm), 32'(irq), 32'(c1 >= (trig ? 4 : 1)));
        check($sformatf("R6 %s status count", nm), s, 32'(c1));
        for (int i = 0; i < c1; i++) begin
            rd(R_DATA, w);
            check($sformatf("R3 R4 R5 %s word %0d", nm, i), w, exp_word(i, pen, fx, fy));
        end
        rd(R_STAT, s);
        check($sformatf("R6 %s empty after drain", nm), s, 32'h080);
        check($sformatf("R8 %s irq after drain", nm), 32'(irq), 32'h0);
    endtask

    task automatic run_overrun();
        logic [31:0] s, w, lastw;
        bit seen3, seen4;
        seen3 = 1'b0; seen4 = 1'b0;
        prep(1, 1, 1, 1, 1, 1, 1'b1);
        wr(R_CTRL, 32'h801);
        for (int k = 0; k < 2000; k++) begin
            rd(R_STAT, s);
            if (s[3:0] == 4'd3 && !seen3) begin
                seen3 = 1'b1;
                check("R8 trigger 4 not reached at 3", 32'(irq), 32'h0);
            end
            if (s[3:0] >= 4'd4 && !seen4) begin
                seen4 = 1'b1;
                check("R8 trigger 4 reached", 32'(irq), 32'h1);
            end
            if (s[8]) break;
        end
        wr(R_CTRL, 32'h800);
        repeat (60) @(negedge clk);
        rd(R_STAT, s);
        check("R7 full with overrun", s, 32'h108);
        for (int i = 0; i < 7; i++) begin
            rd(R_DATA, w);
            check($sformatf("R7 R5 kept word %0d", i), w, exp_word(i, 1'b1, 0, 0));
        end
        rd(R_STAT, s);
        check("R7 overrun sticks with one left", s, 32'h101);
        rd(R_DATA, lastw);
        check("R7 R5 kept word 7", lastw, exp_word(7, 1'b1, 0, 0));
        rd(R_STAT, s);
        check("R7 overrun cleared when empty", s, 32'h080);
        rd(R_DATA, w);
        check("R5 empty read repeats last word", w, lastw);
        rd(R_STAT, s);
        check("R5 empty read keeps count", s, 32'h080);
    endtask

    initial begin
        logic [31:0] r, v;
        int unused_seed;
        unused_seed = int'($urandom(32'h5EED));
        rst = 1'b1; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        pen_down = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 irq reset", 32'(irq), 32'h0);
        check("R1 adc_req reset", 32'(adc_req), 32'h0);
        check("R1 adc_pwr reset", 32'(adc_pwr), 32'h0);
        rd(R_CTRL, r); check("R1 ctrl reset", r, 32'h0);
        rd(R_STAT, r); check("R1 status reset", r, 32'h080);
        rd(4'd3, r); check("R1 settle X default", r, 32'd2);
        rd(4'd4, r); check("R1 settle Y default", r, 32'd2);
        rd(4'd5, r); check("R1 discharge default", r, 32'd4);
        rd(4'd6, r); check("R1 touch default", r, 32'd16);
        rd(4'd7, r); check("R1 update default", r, 32'd88);
        rd(4'd8, r); check("R1 X low default", r, 32'h0);
        rd(4'd9, r); check("R1 X high default", r, 32'h3FF);
        rd(4'd10, r); check("R1 Y low default", r, 32'h0);
        rd(4'd11, r); check("R1 Y high default", r, 32'h3FF);

        // R10 power bit
        wr(R_CTRL, 32'h4);
        check("R10 power on", 32'(adc_pwr), 32'h1);
        rd(R_CTRL, r); check("R10 power readback", r, 32'h4);
        wr(R_CTRL, 32'h0);
        check("R10 power off", 32'(adc_pwr), 32'h0);

        // R11 readback of random writes
        for (int k = 0; k < 3; k++) begin
            for (int a = 3; a <= 11; a++) begin
                v = $urandom;
                wr(4'(a), v);
                rd(4'(a), r);
                check($sformatf("R11 readback reg %0d", a), r,
                      (a <= 7) ? (v & 32'hFF) : (v & 32'h3FF));
            end
            v = $urandom & ~32'h1;
            wr(R_CTRL, v);
            rd(R_CTRL, r);
            check("R11 ctrl readback", r, v & 32'hBF5);
            wr(R_CTRL, 32'h0);
        end

        // directed scans
        run_seg("default timing", 2, 2, 4, 16, 88, 2, 0, 0, 1'b1, 1'b0, 2);
        run_seg("zero delays", 0, 0, 0, 0, 0, 1, 0, 0, 1'b0, 1'b1, 4);
        run_seg("coarse res", 1, 3, 2, 1, 2, 3, 7, 3, 1'b1, 1'b0, 3);

        // random scans
        for (int k = 0; k < 6; k++) begin
            run_seg($sformatf("random %0d", k),
                    int'($urandom_range(6, 0)), int'($urandom_range(6, 0)),
                    int'($urandom_range(6, 0)), int'($urandom_range(6, 0)),
                    int'($urandom_range(6, 0)), int'($urandom_range(4, 1)),
                    int'($urandom_range(7, 0)), int'($urandom_range(7, 0)),
                    1'($urandom), 1'($urandom), int'($urandom_range(5, 2)));
        end

        run_overrun();

        summary();
        $finish;
    end

endmodule